// File: doc/BRIEF.md
# ALU with Condition Flag

This block is the execute stage of a small 16-bit register machine. Each transaction carries a decoded operation code, the two register values named by the instruction (the source `rS` and the destination `rD`) and, for the immediate load, the 16-bit extension word. The block computes the value to be written back to `rD`, flags whether a write-back is due, and keeps a 16-bit status word whose bit 0 is the condition flag used by later conditional branches. A separate debug-mode bit is set and cleared by two dedicated operations.

Transactions enter on a valid/ready handshake and leave one cycle later from a single output register, also valid/ready. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low the result and write-enable stay frozen and no new operation is taken. The status word and the debug bit change on the accepting edge, so they are visible together with the result.

The three compare-style operations produce an output beat with the write-enable low and touch only bit 0 of the status word; every other operation leaves the status word alone.

Top module: `alu_flag_unit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `in_ready` is 1, `status` is 0x0000 and `debug_mode` is 0.
- R2: Codes 1 (add), 2 (sub) and 3 (mul) return `rd_val + rs_val`, `rd_val - rs_val` and the low 16 bits of `rd_val * rs_val`, all wrapping modulo 2^16, with `res_we` = 1.
- R3: Codes 4 (and), 5 (or) and 6 (xor) return the bitwise combination of `rd_val` and `rs_val`; code 7 (move) returns `rs_val`; all with `res_we` = 1.
- R4: Codes 8 (negate), 9 (complement), 10 (increment) and 11 (decrement) act on `rd_val` alone: two's-complement negation, bitwise NOT, plus 1 and minus 1, wrapping, with `res_we` = 1.
- R5: Code 12 (load immediate) returns `imm` with `res_we` = 1.
- R6: Code 16 (test) sets `status[0]` when `rs_val & rd_val` is nonzero and clears it otherwise.
- R7: Code 17 (compare) sets `status[0]` when `rs_val < rd_val` as unsigned 16-bit numbers and clears it otherwise.
- R8: Code 18 (equal) sets `status[0]` when `rs_val == rd_val` and clears it otherwise.
- R9: Compare-style codes 16 to 18 give an output beat with `res_we` = 0 and leave `status[15:1]` unchanged; no other code changes `status`.
- R10: Code 20 sets `debug_mode`, code 21 clears it; both give an output beat with `res_we` = 0 and leave `status` unchanged.
- R11: An accepted operation appears on the output on the next rising edge; while `out_valid` is 1 and `out_ready` is 0, `res` and `res_we` hold and `in_ready` is 0.
- R12: Code 0 and every code not listed above give an output beat with `res_we` = 0 and change neither `status` nor `debug_mode`; a cycle without acceptance changes neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can take an operation this cycle |
| op_code | input | 5 | Decoded operation code |
| rs_val | input | 16 | Source register value (first compare operand) |
| rd_val | input | 16 | Destination register value (second compare operand) |
| imm | input | 16 | Extension word for load immediate |
| out_valid | output | 1 | Result register holds a beat |
| out_ready | input | 1 | Consumer takes the beat this cycle |
| res | output | 16 | Value for write-back to the destination |
| res_we | output | 1 | Write-back due for this beat |
| status | output | 16 | Status word, bit 0 is the condition flag |
| debug_mode | output | 1 | Debug-mode bit |

## Verification
Every operation code is driven with operand pairs chosen at the wrap points (0x0000, 0xFFFF, 0x8000), so that an off-by-one in increment or decrement, a signed compare in place of an unsigned one, or a truncation slip in the product shows up as a wrong value. The compare-style codes are run with both outcomes back to back, so a flag that is only ever set, or that spills into upper status bits, is told apart from a correct one. A stall phase holds `out_ready` low while `in_valid` stays high, separating a correct hold from a design that overwrites or drops beats, and a long random phase with random valid and ready mixes all codes including unlisted ones against the bench's behavioural model on every cycle.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int DATA_W = 16;
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 5'd0,
    OP_ADD   = 5'd1,
    OP_SUB   = 5'd2,
    OP_MUL   = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_MOV   = 5'd7,
    OP_NEG   = 5'd8,
    OP_NOT   = 5'd9,
    OP_INC   = 5'd10,
    OP_DEC   = 5'd11,
    OP_LDI   = 5'd12,
    OP_TEST  = 5'd16,
    OP_CMP   = 5'd17,
    OP_EQU   = 5'd18,
    OP_DBGON = 5'd20,
    OP_DBGOFF= 5'd21
  } alu_op_e;
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [OP_W-1:0] op_code,
  input  logic [W-1:0]    rs_val,
  input  logic [W-1:0]    rd_val,
  input  logic [W-1:0]    imm,
  output logic [W-1:0]    value,
  output logic            we
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    value = '0;
    we    = 1'b1;
    case (op_code)
      OP_ADD: value = rd_val + rs_val;
      OP_SUB: value = rd_val - rs_val;
      OP_MUL: value = rd_val * rs_val;
      OP_AND: value = rd_val & rs_val;
      OP_OR:  value = rd_val | rs_val;
      OP_XOR: value = rd_val ^ rs_val;
      OP_MOV: value = rs_val;
      OP_NEG: value = '0 - rd_val;
      OP_NOT: value = ~rd_val;
      OP_INC: value = rd_val + ONE;
      OP_DEC: value = rd_val - ONE;
      OP_LDI: value = imm;
      default: we = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [OP_W-1:0] op_code,
  input  logic [W-1:0]    lhs,
  input  logic [W-1:0]    rhs,
  output logic            is_cond,
  output logic            cond_bit
);
  always_comb begin
    is_cond  = 1'b1;
    cond_bit = 1'b0;
    case (op_code)
      OP_TEST: cond_bit = |(lhs & rhs);
      OP_CMP:  cond_bit = (lhs < rhs);
      OP_EQU:  cond_bit = (lhs == rhs);
      default: is_cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d_val,
  input  logic         d_we,
  input  logic         out_ready,
  output logic         can_take,
  output logic         out_valid,
  output logic [W-1:0] q_val,
  output logic         q_we
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_val     <= '0;
      q_we      <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      q_val     <= d_val;
      q_we      <= d_we;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rd_val,
  input  logic [DATA_W-1:0] imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] res,
  output logic              res_we,
  output logic [DATA_W-1:0] status,
  output logic              debug_mode
);
  logic              accept;
  logic [DATA_W-1:0] dp_value;
  logic              dp_we;
  logic              is_cond;
  logic              cond_bit;
  logic [DATA_W-1:0] status_q;
  logic              dbg_q;

  assign accept = in_valid && in_ready;

  alu_datapath #(.W(DATA_W)) u_dp (
    .op_code (op_code),
    .rs_val  (rs_val),
    .rd_val  (rd_val),
    .imm     (imm),
    .value   (dp_value),
    .we      (dp_we)
  );

  alu_cond_eval #(.W(DATA_W)) u_cond (
    .op_code  (op_code),
    .lhs      (rs_val),
    .rhs      (rd_val),
    .is_cond  (is_cond),
    .cond_bit (cond_bit)
  );

  alu_out_stage #(.W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .d_val     (dp_value),
    .d_we      (dp_we),
    .out_ready (out_ready),
    .can_take  (in_ready),
    .out_valid (out_valid),
    .q_val     (res),
    .q_we      (res_we)
  );

  // Condition flag: only bit 0 is ever written, upper bits keep their value.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (accept && is_cond) begin
      status_q[0] <= cond_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_q <= 1'b0;
    end else if (accept && op_code == OP_DBGON) begin
      dbg_q <= 1'b1;
    end else if (accept && op_code == OP_DBGOFF) begin
      dbg_q <= 1'b0;
    end
  end

  assign status     = status_q;
  assign debug_mode = dbg_q;
endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk
  import alu_flag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   op_code,
  input logic [DATA_W-1:0] rs_val,
  input logic [DATA_W-1:0] rd_val,
  input logic [DATA_W-1:0] imm,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] res,
  input logic              res_we,
  input logic [DATA_W-1:0] status,
  input logic              debug_mode
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == OP_ADD |=> res_we && res == DATA_W'($past(rd_val) + $past(rs_val)));

  p_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == OP_MOV |=> res_we && res == $past(rs_val));

  p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == OP_INC |=> res == DATA_W'($past(rd_val) + 1'b1));

  p_loadi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == OP_LDI |=> res_we && res == $past(imm));

  p_test_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == OP_TEST |=> status[0] == ($past(rs_val & rd_val) != '0));

  p_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == OP_CMP |=> status[0] == ($past(rs_val) < $past(rd_val)));

  p_equ_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_code == OP_EQU |=> status[0] == ($past(rs_val) == $past(rd_val)));

  p_cond_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (op_code == OP_TEST || op_code == OP_CMP || op_code == OP_EQU)
    |=> !res_we && $stable(status[DATA_W-1:1]));

  p_dbg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (op_code == OP_DBGON || op_code == OP_DBGOFF)
    |=> $stable(status) && debug_mode == ($past(op_code) == OP_DBGON));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res) && $stable(res_we));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(status) && $stable(debug_mode));
endmodule

bind alu_flag_unit alu_flag_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .op_code    (op_code),
  .rs_val     (rs_val),
  .rd_val     (rd_val),
  .imm        (imm),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .res        (res),
  .res_we     (res_we),
  .status     (status),
  .debug_mode (debug_mode)
);

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;
  localparam int CLK_P = 10;
  localparam int MAX_CYC = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  op_code = '0;
  logic [15:0] rs_val = '0;
  logic [15:0] rd_val = '0;
  logic [15:0] imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] res;
  logic        res_we;
  logic [15:0] status;
  logic        debug_mode;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Behavioural model state
  bit          m_ov = 1'b0;
  logic [15:0] m_res = '0;
  bit          m_we = 1'b0;
  logic [15:0] m_st = '0;
  bit          m_dbg = 1'b0;
  string       m_tag = "R1";

  alu_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_code(op_code), .rs_val(rs_val), .rd_val(rd_val), .imm(imm),
    .out_valid(out_valid), .out_ready(out_ready), .res(res), .res_we(res_we),
    .status(status), .debug_mode(debug_mode)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic string tag_of(input logic [4:0] c);
    if (c >= 1 && c <= 3)   return "R2";
    if (c >= 4 && c <= 7)   return "R3";
    if (c >= 8 && c <= 11)  return "R4";
    if (c == 12)            return "R5";
    if (c == 16)            return "R6";
    if (c == 17)            return "R7";
    if (c == 18)            return "R8";
    if (c == 20 || c == 21) return "R10";
    return "R12";
  endfunction

  // Reference model, updated on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ov = 0; m_res = '0; m_we = 0; m_st = '0; m_dbg = 0; m_tag = "R1";
    end else begin
      bit acc;
      acc = in_valid && (!m_ov || out_ready);
      if (m_ov && out_ready) m_ov = 0;
      if (acc) begin
        int a, b;
        a = rs_val; b = rd_val;
        m_ov = 1; m_we = 1; m_tag = tag_of(op_code);
        case (op_code)
          1:  m_res = 16'((b + a) % 65536);
          2:  m_res = 16'((b - a + 65536) % 65536);
          3:  m_res = 16'((longint'(b) * longint'(a)) % 65536);
          4:  m_res = rd_val & rs_val;
          5:  m_res = rd_val | rs_val;
          6:  m_res = rd_val ^ rs_val;
          7:  m_res = rs_val;
          8:  m_res = 16'((65536 - b) % 65536);
          9:  m_res = 16'(65535 - b);
          10: m_res = 16'((b + 1) % 65536);
          11: m_res = 16'((b + 65535) % 65536);
          12: m_res = imm;
          default: m_we = 0;
        endcase
        if (op_code == 16) m_st[0] = ((rs_val & rd_val) != 0);
        if (op_code == 17) m_st[0] = (a < b);
        if (op_code == 18) m_st[0] = (a == b);
        if (op_code == 20) m_dbg = 1;
        if (op_code == 21) m_dbg = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Compare outputs against the model a little after each falling edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      bit exp_rdy;
      exp_rdy = !m_ov || out_ready;
      chk(in_ready == exp_rdy, rst_n ? "R11" : "R1", "in_ready", in_ready, exp_rdy);
      chk(out_valid == m_ov, rst_n ? "R11" : "R1", "out_valid", out_valid, m_ov);
      chk(status == m_st, m_tag, "status", status, m_st);
      chk(debug_mode == m_dbg, m_tag, "debug_mode", debug_mode, m_dbg);
      if (rst_n && m_ov) begin
        chk(res_we == m_we, m_tag, "res_we", res_we, m_we);
        if (m_we) chk(res == m_res, m_tag, "res", res, m_res);
      end
    end
  end

  task automatic step(input logic [4:0] c, input logic [15:0] s,
                      input logic [15:0] d, input logic [15:0] im,
                      input bit iv, input bit ordy);
    @(negedge clk);
    op_code = c; rs_val = s; rd_val = d; imm = im;
    in_valid = iv; out_ready = ordy;
  endtask

  task automatic op(input logic [4:0] c, input logic [15:0] s,
                    input logic [15:0] d, input logic [15:0] im);
    step(c, s, d, im, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                                 // R1 checked during reset
    op(1, 16'h0001, 16'hFFFF, 0);                  // R2 add wraps to 0
    op(2, 16'h0001, 16'h0000, 0);                  // R2 sub wraps to FFFF
    op(3, 16'h0100, 16'h1234, 0);                  // R2 mul low half 0x3400
    op(3, 16'hFFFF, 16'hFFFF, 0);                  // R2 mul -> 0x0001
    op(4, 16'hF0F0, 16'h3C3C, 0);                  // R3
    op(5, 16'hF0F0, 16'h0303, 0);                  // R3
    op(6, 16'hFFFF, 16'hA5A5, 0);                  // R3
    op(7, 16'hBEEF, 16'h1111, 0);                  // R3 move
    op(8, 0, 16'h0001, 0);                         // R4 neg -> FFFF
    op(8, 0, 16'h0000, 0);                         // R4 neg 0
    op(8, 0, 16'h8000, 0);                         // R4 neg 8000
    op(9, 0, 16'h00FF, 0);                         // R4 not
    op(10, 0, 16'hFFFF, 0);                        // R4 inc wraps
    op(11, 0, 16'h0000, 0);                        // R4 dec wraps
    op(12, 16'h1111, 16'h2222, 16'hCAFE);          // R5 load immediate
    op(16, 16'h0F00, 16'h00F0, 0);                 // R6 clear
    op(16, 16'h0F80, 16'h0180, 0);                 // R6 set
    op(16, 16'h0000, 16'hFFFF, 0);                 // R6 clear again
    op(17, 16'h0001, 16'h8000, 0);                 // R7 unsigned less -> 1
    op(17, 16'h8000, 16'h0001, 0);                 // R7 -> 0
    op(17, 16'h4444, 16'h4444, 0);                 // R7 equal -> 0
    op(18, 16'h4444, 16'h4444, 0);                 // R8 -> 1
    op(18, 16'h4444, 16'h4445, 0);                 // R8 -> 0
    op(18, 16'h0000, 16'h0000, 0);                 // R8 -> 1
    op(1, 16'h0002, 16'h0003, 0);                  // R9 flag kept by add
    op(20, 16'hFFFF, 16'hFFFF, 0);                 // R10 debug on, flag kept
    op(21, 0, 0, 0);                               // R10 debug off
    op(20, 0, 0, 0);                               // R10 debug on
    op(31, 16'h1234, 16'h1234, 16'h1234);          // R12 unknown code
    op(0, 0, 0, 0);                                // R12 nop
    op(13, 16'h0001, 16'h0001, 0);                 // R12 gap code
    step(0, 0, 0, 0, 1'b0, 1'b1);                  // R12 idle
    // R11 stall: output held while consumer not ready
    op(1, 16'h0005, 16'h0007, 0);
    step(2, 16'h0001, 16'h0001, 0, 1'b1, 1'b0);
    step(18, 16'h0001, 16'h0002, 0, 1'b1, 1'b0);
    step(18, 16'h0001, 16'h0002, 0, 1'b1, 1'b0);
    step(18, 16'h0001, 16'h0002, 0, 1'b1, 1'b1);
    step(0, 0, 0, 0, 1'b0, 1'b1);
    step(0, 0, 0, 0, 1'b0, 1'b1);
    // Random phase across all codes, with random valid and ready
    for (int i = 0; i < 2000; i++) begin
      logic [4:0] c;
      c = 5'($urandom_range(0, 23));
      step(c, 16'($urandom), 16'($urandom), 16'($urandom),
           ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0));
    end
    step(0, 0, 0, 0, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    #2;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, MAX_CYC);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule